// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device side of a three-wire serial EEPROM. A host drives chip select, a serial clock and a serial data line. The block returns read data or a ready/busy flag on one data output, and gives an output enable for an external tri-state pad. A register array of 64 words of 16 bits stands in for the nonvolatile cells. All three serial inputs are synchronized into a faster system clock, and rising edges of the serial clock are detected there, so the whole design is synchronous to `clk`.

Each command is a start bit, a 2-bit opcode and a 6-bit address. WRITE and write-all also carry a 16-bit data word. Programming commands are accepted only while writes are enabled. They launch a self-timed program cycle whose length in system clocks is a parameter. During that cycle no new command is accepted. When the host drops chip select and raises it again, it can poll completion on the data output.

Top module: `tri_wire_eeprom`

## Requirements
- R1: While chip select is high and no command is in progress, serial clocks with data low change nothing and leave the output disabled. The first rising serial clock with data high is taken as the start bit.
- R2: The two bits after the start decode as follows: 10 = READ, 01 = WRITE, 11 = ERASE, and 00 = extended group. In the extended group the top two address bits select the command: 11 enables writes, 00 disables writes, 10 erases all words and 01 writes all words.
- R3: For READ, the rising clock that carries the last address bit drives a single zero with the output enabled. Each following rising clock drives the next word bit, most significant first. The output reflects each edge within 4 system clocks.
- R4: While chip select stays high after a READ word, further clocks stream the following addresses with no new lead zero. The address wraps from 63 to 0.
- R5: Commands without data need 9 clocks including the start bit, and WRITE and write-all need 25. A command cut short by chip select going low has no effect.
- R6: Once a command is complete, clocks and data are ignored until chip select goes low and a new start bit arrives.
- R7: Chip select low resets the command decoder and disables the output.
- R8: After reset, writes are disabled. ERASE, WRITE, erase-all and write-all are ignored until an enable command, and a disable command blocks them again.
- R9: A program cycle lasts PROG_CYCLES system clocks and runs to completion even with chip select low. Start bits are ignored while it is busy.
- R10: If chip select is raised after an accepted programming command, the output is enabled and shows 0 while busy and 1 when ready. Otherwise the output stays disabled outside READ.
- R11: WRITE stores the data word, replacing the old content. ERASE sets one word to FFFF. Erase-all sets every word to FFFF, and write-all sets every word to the data.
- R12: After reset, every word reads FFFF and the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data or ready/busy flag |
| sdo_oe_o | output | 1 | Output enable for the tri-state pad |

## Verification
A wrong bit counter or a wrong opcode latch shows up at the first READ after the fault. The lead zero shifts by a clock, or the word comes back rotated or from the wrong address, and this is visible within 16 serial clocks. A write-enable latch or program commit that misbehaves only shows up one program cycle later, so every programming step is followed by a status poll and a readback. A stuck busy timer shows up as a status flag that never turns ready, or turns ready too early, and the poll window bounds both cases.

// File: rtl/twe_pkg.sv
package twe_pkg;
  typedef enum logic [2:0] {
    PK_NONE, PK_ERASE, PK_WRITE, PK_ERAL, PK_WRAL
  } prog_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_DONE
  } cmd_state_t;

  localparam logic [1:0] OPC_RD  = 2'b10;
  localparam logic [1:0] OPC_WR  = 2'b01;
  localparam logic [1:0] OPC_ER  = 2'b11;
  localparam logic [1:0] OPC_EXT = 2'b00;

  localparam logic [1:0] EXT_EN   = 2'b11;
  localparam logic [1:0] EXT_DS   = 2'b00;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_WRAL = 2'b01;
endpackage

// File: rtl/twe_sync.sv
module twe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_s,
  output logic sdi_s,
  output logic sck_rise,
  output logic cs_rise
);
  logic [STAGES-1:0] cs_p, sck_p, sdi_p;
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '0;
      sck_p <= '0;
      sdi_p <= '0;
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      cs_p  <= {cs_p[STAGES-2:0], cs_i};
      sck_p <= {sck_p[STAGES-2:0], sck_i};
      sdi_p <= {sdi_p[STAGES-2:0], sdi_i};
      sck_q <= sck_p[STAGES-1];
      cs_q  <= cs_p[STAGES-1];
    end
  end

  assign cs_s     = cs_p[STAGES-1];
  assign sdi_s    = sdi_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_q;
  assign cs_rise  = cs_p[STAGES-1] & ~cs_q;
endmodule

// File: rtl/twe_cmd.sv
module twe_cmd
  import twe_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sdi_s,
  input  logic          sck_rise,
  input  logic          cs_rise,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          prog_req,
  output prog_kind_t    prog_kind,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int CW = $clog2((DW > AW) ? DW : AW);
  localparam logic [CW-1:0] ADR_LAST = CW'(AW - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] OPC_LAST = CW'(1);

  cmd_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          wen_q, wen_d;
  logic          arm_q, arm_d;
  logic          stat_q, stat_d;
  logic          sdo_q, sdo_d;
  logic          oe_q, oe_d;
  logic          req_q, req_d;
  prog_kind_t    kind_q, kind_d;

  logic [AW-1:0] addr_shift;
  logic [1:0]    ext_sel;

  assign addr_shift = {addr_q[AW-2:0], sdi_s};
  assign ext_sel    = addr_shift[AW-1 -: 2];
  assign rd_addr    = (state_q == ST_RD) ? addr_q + AW'(1) : addr_shift;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    sh_d    = sh_q;
    wen_d   = wen_q;
    arm_d   = arm_q;
    stat_d  = stat_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    req_d   = 1'b0;
    kind_d  = kind_q;
    if (!cs_s) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
      sdo_d   = 1'b0;
      stat_d  = 1'b0;
    end else begin
      if (cs_rise && arm_q) stat_d = 1'b1;
      if (sck_rise) begin
        unique case (state_q)
          ST_IDLE: begin
            if (sdi_s && !busy) begin
              state_d = ST_OPC;
              cnt_d   = '0;
              stat_d  = 1'b0;
              arm_d   = 1'b0;
            end
          end
          ST_OPC: begin
            op_d = {op_q[0], sdi_s};
            if (cnt_q == OPC_LAST) begin
              state_d = ST_ADR;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          ST_ADR: begin
            addr_d = addr_shift;
            if (cnt_q == ADR_LAST) begin
              cnt_d   = '0;
              state_d = ST_DONE;
              unique case (op_q)
                OPC_RD: begin
                  state_d = ST_RD;
                  oe_d    = 1'b1;
                  sdo_d   = 1'b0;
                  sh_d    = rd_data;
                end
                OPC_WR: state_d = ST_DAT;
                OPC_ER: begin
                  if (wen_q) begin
                    req_d  = 1'b1;
                    kind_d = PK_ERASE;
                    arm_d  = 1'b1;
                  end
                end
                default: begin
                  unique case (ext_sel)
                    EXT_EN: wen_d = 1'b1;
                    EXT_DS: wen_d = 1'b0;
                    EXT_ERAL: begin
                      if (wen_q) begin
                        req_d  = 1'b1;
                        kind_d = PK_ERAL;
                        arm_d  = 1'b1;
                      end
                    end
                    default: state_d = ST_DAT;
                  endcase
                end
              endcase
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          ST_DAT: begin
            sh_d = {sh_q[DW-2:0], sdi_s};
            if (cnt_q == DAT_LAST) begin
              state_d = ST_DONE;
              cnt_d   = '0;
              if (wen_q) begin
                req_d  = 1'b1;
                kind_d = (op_q == OPC_WR) ? PK_WRITE : PK_WRAL;
                arm_d  = 1'b1;
              end
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          ST_RD: begin
            sdo_d = sh_q[DW-1];
            if (cnt_q == DAT_LAST) begin
              sh_d   = rd_data;
              addr_d = addr_q + AW'(1);
              cnt_d  = '0;
            end else begin
              sh_d  = {sh_q[DW-2:0], 1'b0};
              cnt_d = cnt_q + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      sh_q    <= '0;
      wen_q   <= 1'b0;
      arm_q   <= 1'b0;
      stat_q  <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      req_q   <= 1'b0;
      kind_q  <= PK_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      sh_q    <= sh_d;
      wen_q   <= wen_d;
      arm_q   <= arm_d;
      stat_q  <= stat_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
      req_q   <= req_d;
      kind_q  <= kind_d;
    end
  end

  assign prog_req  = req_q;
  assign prog_kind = kind_q;
  assign prog_addr = addr_q;
  assign prog_data = sh_q;
  assign sdo       = stat_q ? ~busy : sdo_q;
  assign sdo_oe    = stat_q | oe_q;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdo_oe); // R7
  AST_PROG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> wen_q); // R8
  AST_READ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && sck_rise && state_q == ST_ADR && cnt_q == ADR_LAST && op_q == OPC_RD)
      |=> (oe_q && !sdo_q)); // R3
  AST_STATUS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(arm_q)); // R10
endmodule

// File: rtl/twe_prog.sv
module twe_prog
  import twe_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  prog_kind_t    kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          commit,
  output prog_kind_t    c_kind,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          commit_q, commit_d;
  prog_kind_t    kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    busy_d   = busy_q;
    tmr_d    = tmr_q;
    commit_d = 1'b0;
    kind_d   = kind_q;
    addr_d   = addr_q;
    data_d   = data_q;
    if (req && !busy_q) begin
      busy_d = 1'b1;
      tmr_d  = TW'(PROG_CYCLES - 1);
      kind_d = kind;
      addr_d = addr;
      data_d = data;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_d   = 1'b0;
        commit_d = 1'b1;
      end else begin
        tmr_d = tmr_q - TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tmr_q    <= '0;
      commit_q <= 1'b0;
      kind_q   <= PK_NONE;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      tmr_q    <= tmr_d;
      commit_q <= commit_d;
      kind_q   <= kind_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign busy   = busy_q;
  assign commit = commit_q;
  assign c_kind = kind_q;
  assign c_addr = addr_q;
  assign c_data = data_q;

  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !busy_q); // R9
  AST_BUSY_ENDS_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> commit_q); // R9
  AST_COMMIT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(busy_q)); // R11
endmodule

// File: rtl/twe_array.sv
module twe_array
  import twe_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  prog_kind_t    kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic hit;
    assign hit = (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '1;
      end else if (we) begin
        unique case (kind)
          PK_ERASE: if (hit) mem[i] <= '1;
          PK_WRITE: if (hit) mem[i] <= data;
          PK_ERAL:  mem[i] <= '1;
          PK_WRAL:  mem[i] <= data;
          default:  ;
        endcase
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tri_wire_eeprom.sv
module tri_wire_eeprom
  import twe_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [1:0] rst_sync;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  logic          cs_s, sdi_s, sck_rise, cs_rise;
  logic          busy, req, commit;
  prog_kind_t    req_kind, c_kind;
  logic [AW-1:0] req_addr, c_addr, rd_addr;
  logic [DW-1:0] req_data, c_data, rd_data;

  twe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(core_rst_n),
    .cs_i(cs_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .cs_s(cs_s), .sdi_s(sdi_s), .sck_rise(sck_rise), .cs_rise(cs_rise)
  );

  twe_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .clk(clk), .rst_n(core_rst_n),
    .cs_s(cs_s), .sdi_s(sdi_s), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .prog_req(req), .prog_kind(req_kind), .prog_addr(req_addr), .prog_data(req_data),
    .sdo(sdo_o), .sdo_oe(sdo_oe_o)
  );

  twe_prog #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(core_rst_n),
    .req(req), .kind(req_kind), .addr(req_addr), .data(req_data),
    .busy(busy), .commit(commit), .c_kind(c_kind), .c_addr(c_addr), .c_data(c_data)
  );

  twe_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(core_rst_n),
    .we(commit), .kind(c_kind), .addr(c_addr), .data(c_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/tri_wire_eeprom_test.sv
module tri_wire_eeprom_test;
  localparam int PROG = 1000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs, sck, sdi;
  logic sdo, oe;

  tri_wire_eeprom #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe)
  );

  int vectors = 0;
  int miscompares = 0;
  int cs_low_run = 0;
  logic [15:0] model [64];
  bit wen = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs) cs_low_run++;
      else cs_low_run = 0;
      if (cs_low_run >= 4) chk("R7 output enable while deselected", {31'd0, oe}, 32'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic bit_io(input logic d, output logic o, output logic e);
    sdi = d;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    o = sdo;
    e = oe;
    sck = 1'b0;
  endtask

  task automatic cs_up();
    sck = 1'b0;
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_dn();
    cs = 1'b0;
    sdi = 1'b0;
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a,
                          output logic o, output logic e);
    bit_io(1'b1, o, e);
    for (int i = 1; i >= 0; i--) bit_io(op[i], o, e);
    for (int i = 5; i >= 0; i--) bit_io(a[i], o, e);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    logic o, e;
    for (int i = 15; i > 15 - nbits; i--) bit_io(d[i], o, e);
  endtask

  task automatic model_prog(input int kind, input int a, input logic [15:0] d);
    if (wen) begin
      case (kind)
        0: model[a] = d;
        1: model[a] = 16'hFFFF;
        2: for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        default: for (int i = 0; i < 64; i++) model[i] = d;
      endcase
    end
  endtask

  task automatic do_read(input string tag, input int a, input int nwords);
    logic o, e;
    logic [15:0] w;
    logic all_e;
    cs_up();
    send_hdr(2'b10, 6'(a), o, e);
    chk({tag, " lead zero (R3)"}, {30'd0, e, o}, 32'h2);
    for (int k = 0; k < nwords; k++) begin
      w = '0;
      all_e = 1'b1;
      for (int b = 0; b < 16; b++) begin
        bit_io(1'b0, o, e);
        w = {w[14:0], o};
        all_e &= e;
      end
      chk({tag, " word"}, {15'd0, all_e, w}, {15'd0, 1'b1, model[(a + k) % 64]});
    end
    cs_dn();
  endtask

  task automatic wait_ready(input string tag);
    int n;
    cs_dn();
    cs_up();
    chk({tag, " busy status (R10)"}, {30'd0, oe, sdo}, 32'h2);
    n = 0;
    while (sdo !== 1'b1 && n < 3 * PROG) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " ready status (R10)"}, {30'd0, oe, sdo}, 32'h3);
    chk({tag, " cycle length (R9)"}, {31'd0, (n > PROG / 2 && n < PROG)}, 32'd1);
    cs_dn();
  endtask

  task automatic no_status(input string tag);
    cs_dn();
    cs_up();
    chk({tag, " no status"}, {31'd0, oe}, 32'd0);
    cs_dn();
  endtask

  initial begin
    logic o, e;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    rst_n = 1'b0; cs = 1'b0; sck = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 reset output enable", {31'd0, oe}, 32'd0);

    do_read("R12 erased after reset", 5, 1);

    // R8: write while disabled is dropped and arms no status
    cs_up(); send_hdr(2'b01, 6'd5, o, e); send_data(16'h1234, 16);
    model_prog(0, 5, 16'h1234);
    no_status("R8 disabled write");
    do_read("R8 disabled write ignored", 5, 1);

    // R1: idle clocks with data low, then enable in the same select window
    cs_up();
    for (int i = 0; i < 6; i++) begin
      bit_io(1'b0, o, e);
      chk("R1 idle clock", {31'd0, e}, 32'd0);
    end
    send_hdr(2'b00, 6'b110000, o, e);
    wen = 1;
    cs_dn();

    // R10: select held high after write keeps output disabled
    cs_up(); send_hdr(2'b01, 6'd63, o, e); send_data(16'hA5A5, 16);
    bit_io(1'b0, o, e);
    chk("R10 held select no status", {31'd0, e}, 32'd0);
    model_prog(0, 63, 16'hA5A5);
    wait_ready("R11 write 63");

    // R6: trailing ones after a complete enable would form ERASE 63 if parsed
    cs_up(); send_hdr(2'b00, 6'b110000, o, e);
    for (int i = 0; i < 9; i++) bit_io(1'b1, o, e);
    no_status("R6 trailing clocks");
    do_read("R6 trailing clocks ignored", 63, 1);

    // R9: command during busy is ignored; deselect does not abort
    cs_up(); send_hdr(2'b01, 6'd5, o, e); send_data(16'h1234, 16);
    model_prog(0, 5, 16'h1234);
    cs_dn(); cs_up();
    send_hdr(2'b01, 6'd6, o, e); send_data(16'hABCD, 16);
    wait_ready("R9 busy window");
    do_read("R11 write 5", 5, 1);
    do_read("R9 write while busy dropped", 6, 1);

    cs_up(); send_hdr(2'b01, 6'd0, o, e); send_data(16'h0F0F, 16);
    model_prog(0, 0, 16'h0F0F);
    wait_ready("R2 write 0");
    do_read("R4 sequential wrap", 63, 3);

    cs_up(); send_hdr(2'b11, 6'd5, o, e);
    model_prog(1, 5, 16'h0);
    wait_ready("R2 erase");
    do_read("R11 erase word", 5, 1);

    // R8: disable then write is dropped
    cs_up(); send_hdr(2'b00, 6'b000000, o, e); cs_dn();
    wen = 0;
    cs_up(); send_hdr(2'b01, 6'd0, o, e); send_data(16'h1111, 16);
    no_status("R8 after disable");
    do_read("R8 disable blocks write", 0, 1);

    cs_up(); send_hdr(2'b00, 6'b110000, o, e); cs_dn();
    wen = 1;

    // R5: truncated write has no effect
    cs_up(); send_hdr(2'b01, 6'd7, o, e); send_data(16'h0000, 8);
    no_status("R5 truncated");
    do_read("R5 truncated write", 7, 1);

    cs_up(); send_hdr(2'b00, 6'b010000, o, e); send_data(16'h3C3C, 16);
    model_prog(3, 0, 16'h3C3C);
    wait_ready("R2 write all");
    do_read("R11 write all", 0, 1);
    do_read("R11 write all", 40, 1);

    cs_up(); send_hdr(2'b00, 6'b100000, o, e);
    model_prog(2, 0, 16'h0);
    wait_ready("R2 erase all");
    do_read("R11 erase all", 10, 1);
    do_read("R11 erase all", 62, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule